// File: doc/BRIEF.md
# Scalar Double Move and Merge Unit

This block is the execution stage for a family of scalar 64-bit floating-point move operations on wide vector registers. Each valid cycle it takes an already decoded operation (encoding class, the low opcode bit, whether the r/m operand is a register, the 4-bit extra-register field, and writemask controls) together with the operand values. From these it forms one of two results. The first is the new destination register value with a write enable and an indication of which register field names the destination. The second is a 64-bit memory store with its enable. An invalid-opcode fault is flagged when the operation is illegal.

The register width is set by the parameter `VLEN` (default 512). What happens to the bits above the low 64 depends on the encoding class and the operand form. Legacy forms keep some old upper bits. The newer forms clear the upper bits or take them from the first source. Under the extended encoding, an active writemask gates the low lane, and a cleared mask bit either keeps or zeroes it. All outputs are registered, so a result appears one clock after its inputs.

Top module: `sdmove_unit`

## Requirements
- R1: Legacy (`enc_cls`=2'b00) register form: `reg_wdata[63:0]` = `src2_lo`, and bits `VLEN-1:64` equal `dst_old[VLEN-1:64]`; `vvvv` is ignored.
- R2: Legacy load (`opc_hi`=0, `rm_is_reg`=0): `reg_wdata[63:0]` = `mem_rdata`, bits 127:64 are zero, and bits `VLEN-1:128` equal `dst_old`.
- R3: Three-operand register form under `enc_cls` 2'b01 or 2'b10: `reg_wdata[63:0]` = `src2_lo`, bits 127:64 = `src1_hi`, and bits `VLEN-1:128` are zero; `vvvv` is a source here and never faults.
- R4: Load under `enc_cls` 2'b01 or 2'b10: `reg_wdata[63:0]` = `mem_rdata` and bits `VLEN-1:64` are zero.
- R5: With `enc_cls`=2'b10 and `mask_on`=1, the low lane is written only if `mask_k0`=1. Otherwise it keeps `dst_old[63:0]` when `mask_zero`=0, or becomes zero when `mask_zero`=1. With `mask_on`=0, or under another class, the mask inputs have no effect.
- R6: A store (`opc_hi`=1, `rm_is_reg`=0) never asserts `reg_we`. It asserts `mem_we` with `mem_wdata`=`src2_lo`, except under `enc_cls`=2'b10 with `mask_on`=1 and `mask_k0`=0, where no store is made; `mask_zero` has no effect on stores.
- R7: `ud_fault` is raised when `enc_cls`=2'b11, or when `enc_cls` is 2'b01 or 2'b10 with `rm_is_reg`=0 and `vvvv`≠4'b1111. In the cycle a fault is shown, `reg_we` and `mem_we` are both low.
- R8: When `reg_we` is high, `dst_is_rm` is 1 for the register form with `opc_hi`=1 and 0 for every form with `opc_hi`=0.
- R9: Results appear one clock after a cycle with `in_valid`=1. After reset, and after a cycle with `in_valid`=0, `reg_we`, `mem_we` and `ud_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| enc_cls | input | 2 | 00 legacy, 01 VEX, 10 EVEX, 11 reserved |
| opc_hi | input | 1 | Opcode low bit: 0 load/merge, 1 store/merge |
| rm_is_reg | input | 1 | r/m operand is a register (1) or memory (0) |
| vvvv | input | 4 | Extra register field |
| mask_on | input | 1 | A writemask other than k0 is in effect |
| mask_k0 | input | 1 | Bit 0 of the writemask |
| mask_zero | input | 1 | 1 zeroing masking, 0 merge masking |
| src1_hi | input | 64 | Bits 127:64 of the first-source register |
| src2_lo | input | 64 | Low 64 bits of the register that supplies the scalar |
| dst_old | input | VLEN | Current value of the destination register |
| mem_rdata | input | 64 | Memory read data for loads |
| reg_we | output | 1 | Destination register write enable |
| dst_is_rm | output | 1 | Destination is the r/m register (1) or the reg register (0) |
| reg_wdata | output | VLEN | New destination register value |
| mem_we | output | 1 | Memory store enable |
| mem_wdata | output | 64 | Store data |
| ud_fault | output | 1 | Invalid-opcode fault |

## Verification
The bench sweeps every combination of encoding class, opcode bit, operand form, mask controls and three `vvvv` values, including 0000 and 0111. A design that checked the reserved field on register forms would fault on valid three-operand merges. A design that skipped the check would write on illegal loads and stores. Masked-off zeroing stores are the key store case: a design that let zeroing apply there would either write zero to memory or drop the store where a merge was due. Upper-bit handling is compared bit for bit, so a legacy load that cleared everything above bit 64, or a newer form that kept old bits above 127, shows up directly in `reg_wdata`.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [1:0] {
    ENC_LEG  = 2'b00,
    ENC_VEX  = 2'b01,
    ENC_EVEX = 2'b10,
    ENC_RSVD = 2'b11
  } enc_e;

  localparam int unsigned LANE_W = 64;
endpackage

// File: rtl/sdm_decode.sv
module sdm_decode
  import sdm_pkg::*;
(
  input  logic [1:0] enc_cls,
  input  logic       opc_hi,
  input  logic       rm_is_reg,
  input  logic [3:0] vvvv,
  input  logic       mask_on,
  input  logic       mask_k0,
  output logic       fault,
  output logic       store_form,
  output logic       legacy,
  output logic       lane_pass,
  output logic       dst_is_rm
);
  enc_e enc;
  logic masked;

  always_comb begin
    enc        = enc_e'(enc_cls);
    legacy     = (enc == ENC_LEG);
    store_form = opc_hi && !rm_is_reg;
    // memory forms of the newer encodings reserve the extra field
    fault      = (enc == ENC_RSVD) ||
                 (!legacy && !rm_is_reg && (vvvv != 4'b1111));
    masked     = (enc == ENC_EVEX) && mask_on;
    lane_pass  = !masked || mask_k0;
    dst_is_rm  = opc_hi && rm_is_reg;
  end
endmodule

// File: rtl/sdm_lane.sv
module sdm_lane #(
  parameter int unsigned W = 64
) (
  input  logic         from_reg,
  input  logic         pass,
  input  logic         zero_mode,
  input  logic [W-1:0] reg_src,
  input  logic [W-1:0] mem_src,
  input  logic [W-1:0] old_lane,
  output logic [W-1:0] lane
);
  logic [W-1:0] picked;

  always_comb begin
    picked = from_reg ? reg_src : mem_src;
    if (pass)           lane = picked;
    else if (zero_mode) lane = '0;
    else                lane = old_lane;
  end
endmodule

// File: rtl/sdm_upper.sv
module sdm_upper #(
  parameter int unsigned VLEN = 512
) (
  input  logic             legacy,
  input  logic             from_reg,
  input  logic [63:0]      src1_hi,
  input  logic [VLEN-1:64] old_upper,
  output logic [VLEN-1:64] upper
);
  logic [63:0] mid;

  always_comb begin
    if (legacy) mid = from_reg ? old_upper[127:64] : 64'd0;
    else        mid = from_reg ? src1_hi : 64'd0;
  end

  generate
    if (VLEN > 128) begin : g_wide
      logic [VLEN-1:128] top_bits;
      always_comb top_bits = legacy ? old_upper[VLEN-1:128] : '0;
      assign upper = {top_bits, mid};
    end else begin : g_narrow
      assign upper = mid;
    end
  endgenerate
endmodule

// File: rtl/sdmove_unit.sv
module sdmove_unit
  import sdm_pkg::*;
#(
  parameter int unsigned VLEN = 512
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      enc_cls,
  input  logic            opc_hi,
  input  logic            rm_is_reg,
  input  logic [3:0]      vvvv,
  input  logic            mask_on,
  input  logic            mask_k0,
  input  logic            mask_zero,
  input  logic [63:0]     src1_hi,
  input  logic [63:0]     src2_lo,
  input  logic [VLEN-1:0] dst_old,
  input  logic [63:0]     mem_rdata,
  output logic            reg_we,
  output logic            dst_is_rm,
  output logic [VLEN-1:0] reg_wdata,
  output logic            mem_we,
  output logic [63:0]     mem_wdata,
  output logic            ud_fault
);
  localparam int unsigned UPPER_W = VLEN - LANE_W;

  logic fault_c, store_c, legacy_c, pass_c, rmdst_c;
  logic [LANE_W-1:0]  lane_c;
  logic [VLEN-1:64]   upper_c;

  sdm_decode u_dec (
    .enc_cls   (enc_cls),
    .opc_hi    (opc_hi),
    .rm_is_reg (rm_is_reg),
    .vvvv      (vvvv),
    .mask_on   (mask_on),
    .mask_k0   (mask_k0),
    .fault     (fault_c),
    .store_form(store_c),
    .legacy    (legacy_c),
    .lane_pass (pass_c),
    .dst_is_rm (rmdst_c)
  );

  sdm_lane #(.W(LANE_W)) u_lane (
    .from_reg (rm_is_reg),
    .pass     (pass_c),
    .zero_mode(mask_zero),
    .reg_src  (src2_lo),
    .mem_src  (mem_rdata),
    .old_lane (dst_old[LANE_W-1:0]),
    .lane     (lane_c)
  );

  sdm_upper #(.VLEN(VLEN)) u_up (
    .legacy   (legacy_c),
    .from_reg (rm_is_reg),
    .src1_hi  (src1_hi),
    .old_upper(dst_old[VLEN-1:64]),
    .upper    (upper_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we    <= 1'b0;
      mem_we    <= 1'b0;
      ud_fault  <= 1'b0;
      dst_is_rm <= 1'b0;
      reg_wdata <= '0;
      mem_wdata <= '0;
    end else begin
      ud_fault  <= in_valid && fault_c;
      reg_we    <= in_valid && !fault_c && !store_c;
      mem_we    <= in_valid && !fault_c && store_c && pass_c;
      dst_is_rm <= rmdst_c;
      reg_wdata <= {upper_c, lane_c};
      mem_wdata <= src2_lo;
    end
  end

  AST_FAULT_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (rst)
    ud_fault |-> (!reg_we && !mem_we)); // R7

  AST_STORE_NOT_REG: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !reg_we); // R6

  AST_RSVD_FIELD_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (enc_cls != 2'b00) && !rm_is_reg && (vvvv != 4'b1111)) |=> ud_fault); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!reg_we && !mem_we && !ud_fault)); // R9

  AST_LEG_REG_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (enc_cls == 2'b00) && rm_is_reg)
      |=> (reg_wdata[VLEN-1:64] == $past(dst_old[VLEN-1:64]))); // R1

  generate
    if (VLEN > 128) begin : g_chk_wide
      AST_NEW_ENC_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (enc_cls != 2'b00) && !(opc_hi && !rm_is_reg))
          |=> (reg_wdata[VLEN-1:128] == '0)); // R3
    end
  endgenerate

  initial begin
    AST_WIDTH_OK: assert (UPPER_W >= 64); // R1
  end
endmodule

// File: tb/sdmove_unit_tb.sv
module sdmove_unit_tb;
  localparam int unsigned VL = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [1:0]    enc_cls = '0;
  logic          opc_hi = 1'b0, rm_is_reg = 1'b0;
  logic [3:0]    vvvv = 4'hF;
  logic          mask_on = 1'b0, mask_k0 = 1'b0, mask_zero = 1'b0;
  logic [63:0]   src1_hi = '0, src2_lo = '0, mem_rdata = '0;
  logic [VL-1:0] dst_old = '0;
  logic          reg_we, dst_is_rm, mem_we, ud_fault;
  logic [VL-1:0] reg_wdata;
  logic [63:0]   mem_wdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  sdmove_unit #(.VLEN(VL)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc_cls(enc_cls),
    .opc_hi(opc_hi), .rm_is_reg(rm_is_reg), .vvvv(vvvv),
    .mask_on(mask_on), .mask_k0(mask_k0), .mask_zero(mask_zero),
    .src1_hi(src1_hi), .src2_lo(src2_lo), .dst_old(dst_old),
    .mem_rdata(mem_rdata), .reg_we(reg_we), .dst_is_rm(dst_is_rm),
    .reg_wdata(reg_wdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .ud_fault(ud_fault)
  );

  task automatic check(input string tag, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VL-1:0] patt(input int unsigned s);
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++)
      v[i*32 +: 32] = (s * 32'h9E3779B1) ^ (i * 32'h85EBCA6B) ^ 32'h5A5A0001;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] vsel [3];
    int unsigned seed;
    vsel[0] = 4'hF; vsel[1] = 4'h0; vsel[2] = 4'h7;
    seed = 1;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 reset reg_we", VL'(reg_we), '0);
    check("R9 reset mem_we", VL'(mem_we), '0);
    check("R9 reset ud_fault", VL'(ud_fault), '0);

    for (int e = 0; e < 4; e++)
    for (int o = 0; o < 2; o++)
    for (int r = 0; r < 2; r++)
    for (int vs = 0; vs < 3; vs++)
    for (int m = 0; m < 8; m++) begin
      logic x_fault, x_store, x_pass, x_rwe, x_mwe;
      logic [63:0] x_lo, pick;
      logic [VL-1:0] x_data;
      string tag;

      in_valid  = 1'b1;
      enc_cls   = 2'(e);
      opc_hi    = o[0];
      rm_is_reg = r[0];
      vvvv      = vsel[vs];
      mask_on   = m[0];
      mask_k0   = m[1];
      mask_zero = m[2];
      dst_old   = patt(seed);
      src1_hi   = patt(seed + 7)[63:0];
      src2_lo   = patt(seed + 13)[63:0];
      mem_rdata = patt(seed + 29)[63:0];
      seed      = seed + 41;

      x_fault = (e == 3) || (e != 0 && r == 0 && vsel[vs] != 4'hF);
      x_store = (o == 1) && (r == 0);
      x_pass  = !(e == 2 && m[0]) || m[1];
      x_rwe   = !x_fault && !x_store;
      x_mwe   = !x_fault && x_store && x_pass;
      pick    = r[0] ? src2_lo : mem_rdata;
      x_lo    = x_pass ? pick : (m[2] ? 64'd0 : dst_old[63:0]);
      if (e == 0)
        x_data = r[0] ? {dst_old[VL-1:64], x_lo}
                      : {dst_old[VL-1:128], 64'd0, x_lo};
      else
        x_data = r[0] ? {{(VL-128){1'b0}}, src1_hi, x_lo}
                      : {{(VL-64){1'b0}}, x_lo};

      if (x_fault)                   tag = "R7";
      else if (x_store)              tag = "R6";
      else if (!x_pass)              tag = "R5";
      else if (e == 0 && r == 1)     tag = "R1";
      else if (e == 0)               tag = "R2";
      else if (r == 1)               tag = "R3";
      else                           tag = "R4";

      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " ud_fault"}, VL'(ud_fault), VL'(x_fault));
      check({tag, " reg_we"},   VL'(reg_we),   VL'(x_rwe));
      check({tag, " mem_we"},   VL'(mem_we),   VL'(x_mwe));
      if (x_rwe) begin
        check({tag, " reg_wdata"}, reg_wdata, x_data);
        check("R8 dst_is_rm", VL'(dst_is_rm), VL'(o == 1 && r == 1));
      end
      if (x_mwe) check({tag, " mem_wdata"}, VL'(mem_wdata), VL'(src2_lo));

      if (m == 7) begin
        @(negedge clk);
        // R9: idle cycle produces no enables
        check("R9 idle reg_we", VL'(reg_we), '0);
        check("R9 idle mem_we", VL'(mem_we), '0);
        check("R9 idle ud_fault", VL'(ud_fault), '0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule